// File: doc/BRIEF.md
# Load Queue Memory-Order Violation Detector

When an older load or store learns its address, some younger load may already have read memory that this access should have fed. This block finds such loads. It walks a circular load queue, one entry per clock, starting just after the requester's own slot. The walk ends at the queue tail, at the first conflicting entry, or at an early stop. A conflict records the entry's sequence number as the violator, so the pipeline can squash and refetch from it.

Addresses are compared as ranges of coarse blocks, not as exact bytes. Each access spans from the block of its first byte to the block of its last byte. A single violator register keeps the oldest offender seen across checks until the pipeline clears it. A counter tallies every recorded violation. Store-triggered checks always run. Load-triggered checks run only when a build parameter allows them.

The queue contents, the tail index and the request fields must stay stable while `busy_o` is high. `DEPTH` must be a power of two. Every access size must be at least 1.

Top module: `lq_order_checker`

## Requirements
- R1: Addresses are reduced to block numbers by a right shift of `BLK_SHIFT` bits (default 4, giving 16-byte blocks). An access spans from block `addr>>BLK_SHIFT` to block `(addr+size-1)>>BLK_SHIFT`.
- R2: A request and an entry conflict when the request's last block is greater than the entry's first block and the request's first block is less than the entry's last block. They also conflict when the two first blocks are equal. No other case is a conflict: for example, request blocks 1..1 against entry blocks 0..1 is not a conflict.
- R3: A scan starts at index `(req_slot_i+1) mod DEPTH` and examines one entry per clock, wrapping from DEPTH-1 to 0, until the index equals `tail_i`. Take the request as sampled at edge E0. If the scan examines m entries and then meets the tail, `done_o` is high in the cycle after edge E(m+1). If the scan ends on its m-th examined entry, `done_o` is high in the cycle after edge E(m).
- R4: An entry whose address-valid bit is 0, or whose uncacheable bit is 1, is passed over without a conflict test.
- R5: If a conflict is found while a violator is held and the entry's sequence number is greater than the held one, the scan stops. `fault_o` is 0, and the held violator and the counter keep their values.
- R6: On any other conflict, the entry's sequence number is stored as the violator. `viol_valid_o` becomes 1, `viol_cnt_o` increases by 1, and `fault_o` is 1 together with `done_o`. A scan that reaches the tail gives `fault_o` = 0.
- R7: A request with `req_is_load_i`=1 scans only when `CHECK_LOADS`=1 (the default). With `CHECK_LOADS`=0, such a request gives `done_o` in the cycle after acceptance, with `fault_o`=0 and no scan.
- R8: `clr_viol_i` drops `viol_valid_o` at the next edge. If a violator is recorded at that same edge, the record wins and `viol_valid_o` stays 1 with the new sequence number.
- R9: After reset, `busy_o`, `done_o`, `fault_o` and `viol_valid_o` are 0 and `viol_cnt_o` is 0.
- R10: A request that arrives while `busy_o` is 1 is ignored. The running scan's result is unchanged, and no further scan follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ent_addr_ok_i | input | DEPTH | Per-entry address-valid bit |
| ent_uncache_i | input | DEPTH | Per-entry uncacheable bit |
| ent_addr_i | input | DEPTH*ADDR_W | Entry addresses, entry i at bits [i*ADDR_W +: ADDR_W] |
| ent_size_i | input | DEPTH*SIZE_W | Entry access sizes in bytes |
| ent_seq_i | input | DEPTH*SEQ_W | Entry sequence numbers |
| tail_i | input | log2(DEPTH) | Queue tail index, where the scan stops |
| req_i | input | 1 | Check request, accepted when idle |
| req_is_load_i | input | 1 | Request comes from a load (1) or a store (0) |
| req_slot_i | input | log2(DEPTH) | Requester's own load-queue slot |
| req_addr_i | input | ADDR_W | Requester address |
| req_size_i | input | SIZE_W | Requester size in bytes |
| clr_viol_i | input | 1 | Clear the held violator |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | Check finished (one cycle per check) |
| fault_o | output | 1 | Check recorded a violation, valid with done_o |
| viol_valid_o | output | 1 | A violator is held |
| viol_seq_o | output | SEQ_W | Sequence number of the held violator |
| viol_cnt_o | output | CNT_W | Count of recorded violations |

## Verification
A new violator record and an external clear can land on the same clock edge. The bench provokes this by pulsing `clr_viol_i` in the exact cycle it predicts a conflicting scan will finish. It then judges the outcome by `viol_valid_o` staying 1 with the new sequence number. The same late pulse is also driven on scans that end at the tail or stop early. In those cases the clear must take effect, and the model tracks both outcomes in the random phase.

// File: rtl/lqv_pkg.sv
package lqv_pkg;
  typedef enum logic {ST_IDLE, ST_SCAN} lqv_state_e;
endpackage

// File: rtl/lqv_span.sv
// Converts a byte range into first and last block numbers.
module lqv_span #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 5,
  parameter int SHIFT  = 4,
  localparam int BW    = ADDR_W - SHIFT
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [BW-1:0]     first_o,
  output logic [BW-1:0]     last_o
);
  logic [ADDR_W-1:0] end_a;
  assign end_a   = addr_i + ADDR_W'(size_i) - ADDR_W'(1);
  assign first_o = BW'(addr_i >> SHIFT);
  assign last_o  = BW'(end_a >> SHIFT);
endmodule

// File: rtl/lqv_conflict.sv
module lqv_conflict #(
  parameter int BW = 28
) (
  input  logic [BW-1:0] a_first_i,
  input  logic [BW-1:0] a_last_i,
  input  logic [BW-1:0] e_first_i,
  input  logic [BW-1:0] e_last_i,
  output logic          hit_o
);
  assign hit_o = ((a_last_i > e_first_i) && (a_first_i < e_last_i)) ||
                 (a_first_i == e_first_i);
endmodule

// File: rtl/lqv_entry_sel.sv
module lqv_entry_sel #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 5,
  parameter int SEQ_W  = 16,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic [IW-1:0]           idx_i,
  input  logic [DEPTH-1:0]        ok_i,
  input  logic [DEPTH-1:0]        unc_i,
  input  logic [DEPTH*ADDR_W-1:0] addr_i,
  input  logic [DEPTH*SIZE_W-1:0] size_i,
  input  logic [DEPTH*SEQ_W-1:0]  seq_i,
  output logic                    skip_o,
  output logic [ADDR_W-1:0]       addr_o,
  output logic [SIZE_W-1:0]       size_o,
  output logic [SEQ_W-1:0]        seq_o
);
  logic [ADDR_W-1:0] addr_a [DEPTH];
  logic [SIZE_W-1:0] size_a [DEPTH];
  logic [SEQ_W-1:0]  seq_a  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_unpack
    assign addr_a[g] = addr_i[g*ADDR_W +: ADDR_W];
    assign size_a[g] = size_i[g*SIZE_W +: SIZE_W];
    assign seq_a[g]  = seq_i[g*SEQ_W +: SEQ_W];
  end

  assign skip_o = !ok_i[idx_i] || unc_i[idx_i];
  assign addr_o = addr_a[idx_i];
  assign size_o = size_a[idx_i];
  assign seq_o  = seq_a[idx_i];
endmodule

// File: rtl/lqv_violator.sv
module lqv_violator #(
  parameter int SEQ_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rec_i,
  input  logic [SEQ_W-1:0] rec_seq_i,
  input  logic             clr_i,
  output logic             valid_o,
  output logic [SEQ_W-1:0] seq_o,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      seq_o   <= '0;
      cnt_o   <= '0;
    end else if (rec_i) begin
      valid_o <= 1'b1;
      seq_o   <= rec_seq_i;
      cnt_o   <= cnt_o + CNT_W'(1);
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end
  end

  p_clr_drops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !rec_i) |=> !valid_o);
  p_rec_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_i |=> (valid_o && seq_o == $past(rec_seq_i)));
  p_cnt_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_i |=> cnt_o == $past(cnt_o) + CNT_W'(1));
  p_cnt_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rec_i |=> $stable(cnt_o));
endmodule

// File: rtl/lq_order_checker.sv
module lq_order_checker
  import lqv_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int ADDR_W      = 32,
  parameter int SIZE_W      = 5,
  parameter int SEQ_W       = 16,
  parameter int CNT_W       = 16,
  parameter int BLK_SHIFT   = 4,
  parameter bit CHECK_LOADS = 1'b1,
  localparam int IW         = $clog2(DEPTH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [DEPTH-1:0]        ent_addr_ok_i,
  input  logic [DEPTH-1:0]        ent_uncache_i,
  input  logic [DEPTH*ADDR_W-1:0] ent_addr_i,
  input  logic [DEPTH*SIZE_W-1:0] ent_size_i,
  input  logic [DEPTH*SEQ_W-1:0]  ent_seq_i,
  input  logic [IW-1:0]           tail_i,
  input  logic                    req_i,
  input  logic                    req_is_load_i,
  input  logic [IW-1:0]           req_slot_i,
  input  logic [ADDR_W-1:0]       req_addr_i,
  input  logic [SIZE_W-1:0]       req_size_i,
  input  logic                    clr_viol_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    fault_o,
  output logic                    viol_valid_o,
  output logic [SEQ_W-1:0]        viol_seq_o,
  output logic [CNT_W-1:0]        viol_cnt_o
);
  localparam int BW = ADDR_W - BLK_SHIFT;

  lqv_state_e        state_q;
  logic [IW-1:0]     idx_q;
  logic [ADDR_W-1:0] ra_q;
  logic [SIZE_W-1:0] rs_q;
  logic              done_q, fault_q;

  logic              accept, run, at_tail, hit, younger, end_scan, rec;
  logic              e_skip;
  logic [ADDR_W-1:0] e_addr;
  logic [SIZE_W-1:0] e_size;
  logic [SEQ_W-1:0]  e_seq;
  logic [BW-1:0]     a_first, a_last, e_first, e_last;

  lqv_entry_sel #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .SEQ_W(SEQ_W)) u_sel (
    .idx_i (idx_q), .ok_i(ent_addr_ok_i), .unc_i(ent_uncache_i),
    .addr_i(ent_addr_i), .size_i(ent_size_i), .seq_i(ent_seq_i),
    .skip_o(e_skip), .addr_o(e_addr), .size_o(e_size), .seq_o(e_seq)
  );

  lqv_span #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .SHIFT(BLK_SHIFT)) u_req_span (
    .addr_i(ra_q), .size_i(rs_q), .first_o(a_first), .last_o(a_last)
  );

  lqv_span #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .SHIFT(BLK_SHIFT)) u_ent_span (
    .addr_i(e_addr), .size_i(e_size), .first_o(e_first), .last_o(e_last)
  );

  lqv_conflict #(.BW(BW)) u_cmp (
    .a_first_i(a_first), .a_last_i(a_last),
    .e_first_i(e_first), .e_last_i(e_last), .hit_o(hit)
  );

  assign accept   = (state_q == ST_IDLE) && req_i;
  assign run      = !req_is_load_i || CHECK_LOADS;
  assign at_tail  = idx_q == tail_i;
  assign younger  = viol_valid_o && (e_seq > viol_seq_o);
  assign end_scan = (state_q == ST_SCAN) && (at_tail || (!e_skip && hit));
  assign rec      = (state_q == ST_SCAN) && !at_tail && !e_skip && hit && !younger;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      ra_q    <= '0;
      rs_q    <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q  <= (accept && !run) || end_scan;
      fault_q <= rec;
      if (accept) begin
        ra_q  <= req_addr_i;
        rs_q  <= req_size_i;
        idx_q <= req_slot_i + IW'(1);
        if (run) state_q <= ST_SCAN;
      end else if (state_q == ST_SCAN) begin
        if (end_scan) state_q <= ST_IDLE;
        else          idx_q   <= idx_q + IW'(1);
      end
    end
  end

  lqv_violator #(.SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_viol (
    .clk_i(clk_i), .rst_ni(rst_ni), .rec_i(rec), .rec_seq_i(e_seq),
    .clr_i(clr_viol_i), .valid_o(viol_valid_o), .seq_o(viol_seq_o), .cnt_o(viol_cnt_o)
  );

  assign busy_o  = state_q == ST_SCAN;
  assign done_o  = done_q;
  assign fault_o = fault_q;

  p_fault_has_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> done_o);
  p_fault_holds_viol_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> viol_valid_o);
  p_stop_keeps_seq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_o) |-> $stable(viol_seq_o));
  p_scan_ends_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o));
  p_scan_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !end_scan) |=> (idx_q == $past(idx_q) + IW'(1)));
  p_busy_ignores_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_i && !end_scan) |=> busy_o);

  if (!CHECK_LOADS) begin : g_noload_chk
    p_noload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept && req_is_load_i) |=> (done_o && !fault_o && !busy_o));
  end
endmodule

// File: tb/tb_lq_order_checker.sv
module tb_lq_order_checker;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8, AW = 32, SW = 5, QW = 16, CW = 16, SH = 4;
  localparam int IW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [DEPTH-1:0]    q_ok = '0, q_unc = '0;
  logic [DEPTH*AW-1:0] q_addr = '0;
  logic [DEPTH*SW-1:0] q_size = '0;
  logic [DEPTH*QW-1:0] q_seq = '0;
  logic [IW-1:0]       tail = '0, slot = '0, slot_nl = '0;
  logic                req = 0, req_ld = 0, clr = 0, req_nl = 0, req_ld_nl = 0;
  logic [AW-1:0]       raddr = '0;
  logic [SW-1:0]       rsize = 5'd1;

  logic busy, done, fault, vval;
  logic [QW-1:0] vseq;
  logic [CW-1:0] vcnt;
  logic busy_nl, done_nl, fault_nl, vval_nl;
  logic [QW-1:0] vseq_nl;
  logic [CW-1:0] vcnt_nl;

  lq_order_checker #(.DEPTH(DEPTH), .ADDR_W(AW), .SIZE_W(SW), .SEQ_W(QW), .CNT_W(CW),
                     .BLK_SHIFT(SH), .CHECK_LOADS(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ent_addr_ok_i(q_ok), .ent_uncache_i(q_unc),
    .ent_addr_i(q_addr), .ent_size_i(q_size), .ent_seq_i(q_seq), .tail_i(tail),
    .req_i(req), .req_is_load_i(req_ld), .req_slot_i(slot), .req_addr_i(raddr),
    .req_size_i(rsize), .clr_viol_i(clr), .busy_o(busy), .done_o(done),
    .fault_o(fault), .viol_valid_o(vval), .viol_seq_o(vseq), .viol_cnt_o(vcnt));

  lq_order_checker #(.DEPTH(DEPTH), .ADDR_W(AW), .SIZE_W(SW), .SEQ_W(QW), .CNT_W(CW),
                     .BLK_SHIFT(SH), .CHECK_LOADS(1'b0)) dut_nl (
    .clk_i(clk), .rst_ni(rst_n), .ent_addr_ok_i(q_ok), .ent_uncache_i(q_unc),
    .ent_addr_i(q_addr), .ent_size_i(q_size), .ent_seq_i(q_seq), .tail_i(tail),
    .req_i(req_nl), .req_is_load_i(req_ld_nl), .req_slot_i(slot_nl), .req_addr_i(raddr),
    .req_size_i(rsize), .clr_viol_i(1'b0), .busy_o(busy_nl), .done_o(done_nl),
    .fault_o(fault_nl), .viol_valid_o(vval_nl), .viol_seq_o(vseq_nl), .viol_cnt_o(vcnt_nl));

  int checks = 0, errors = 0;
  bit finished = 0;
  bit            m_val = 0;
  logic [QW-1:0] m_seq = '0;
  logic [CW-1:0] m_cnt = '0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] blk_first(input logic [AW-1:0] a);
    return a >> SH;
  endfunction
  function automatic logic [AW-1:0] blk_last(input logic [AW-1:0] a, input logic [SW-1:0] s);
    return (a + AW'(s) - 1) >> SH;
  endfunction

  task automatic set_ent(input int i, input bit ok, input bit unc, input logic [AW-1:0] a,
                         input logic [SW-1:0] s, input logic [QW-1:0] q);
    q_ok[i] = ok; q_unc[i] = unc;
    q_addr[i*AW +: AW] = a; q_size[i*SW +: SW] = s; q_seq[i*QW +: QW] = q;
  endtask

  task automatic clear_q();
    for (int i = 0; i < DEPTH; i++) set_ent(i, 0, 0, '0, 5'd1, '0);
  endtask

  // Runs one check on dut; expected result and latency come from the R1..R6 rules.
  task automatic run_check(input string tag, input bit ld, input int s, input logic [AW-1:0] a,
                           input logic [SW-1:0] sz, input bit clr_end, input bit poke);
    int idx, steps, lat, cyc;
    bit rec, efault;
    logic [QW-1:0] rseq;
    logic [AW-1:0] af, al, ef, el;
    idx = (s + 1) % DEPTH; steps = 0; lat = 1; rec = 0; rseq = '0;
    af = blk_first(a); al = blk_last(a, sz);
    for (int n = 0; n <= DEPTH; n++) begin
      if (idx == int'(tail)) begin lat = steps + 1; break; end
      steps++;
      if (!q_ok[idx] || q_unc[idx]) begin idx = (idx + 1) % DEPTH; continue; end
      ef = blk_first(q_addr[idx*AW +: AW]);
      el = blk_last(q_addr[idx*AW +: AW], q_size[idx*SW +: SW]);
      if (((al > ef) && (af < el)) || (af == ef)) begin
        if (!(m_val && (q_seq[idx*QW +: QW] > m_seq))) begin
          rec = 1; rseq = q_seq[idx*QW +: QW];
        end
        lat = steps;
        break;
      end
      idx = (idx + 1) % DEPTH;
    end
    efault = rec;

    @(negedge clk);
    req = 1; req_ld = ld; slot = IW'(s); raddr = a; rsize = sz;
    @(posedge clk); @(negedge clk);
    req = 0;
    cyc = 0;
    while (1) begin
      cyc++;
      if (poke && cyc == 1 && lat > 1) begin
        chk({tag, " R10 busy during scan"}, 64'(busy), 64'd1);
        req = 1; raddr = a ^ 32'h0000_0040; slot = IW'(s + 3);
      end
      if (clr_end && cyc == lat) clr = 1;
      @(posedge clk); @(negedge clk);
      req = 0; clr = 0;
      if (done || cyc > 40) break;
    end
    if (rec) begin m_val = 1; m_seq = rseq; m_cnt = m_cnt + 1'b1; end
    else if (clr_end) m_val = 0;
    chk({tag, " R3 latency"}, 64'(cyc), 64'(lat));
    chk({tag, " R6 fault"}, 64'(fault), 64'(efault));
    chk({tag, " R8 viol_valid"}, 64'(vval), 64'(m_val));
    if (m_val) chk({tag, " R5 viol_seq"}, 64'(vseq), 64'(m_seq));
    chk({tag, " R6 count"}, 64'(vcnt), 64'(m_cnt));
    if (poke) begin
      @(posedge clk); @(negedge clk);
      chk({tag, " R10 no extra scan"}, {62'd0, busy, done}, 64'd0);
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1; @(posedge clk); @(negedge clk); clr = 0;
    m_val = 0;
    chk("R8 clear", 64'(vval), 64'd0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 reset busy/done/fault", {61'd0, busy, done, fault}, 64'd0);
    chk("R9 reset viol", {47'd0, vval, vcnt}, 64'd0);

    // R3/R4: nothing valid, walk to tail
    clear_q(); tail = 3'd5;
    run_check("walk-empty", 0, 1, 32'h10, 5'd1, 0, 0);
    // R1/R2: same first block
    set_ent(3, 1, 0, 32'h1F, 5'd1, 16'd50);
    run_check("same-block", 0, 1, 32'h10, 5'd1, 0, 0);
    pulse_clr();
    // R2: request 1..1 vs entry 0..1 is not a conflict
    clear_q(); set_ent(3, 1, 0, 32'h0F, 5'd2, 16'd50);
    run_check("strict-edge", 0, 1, 32'h10, 5'd1, 0, 0);
    // R1/R2: request blocks 0..2 covers entry block 1
    clear_q(); set_ent(3, 1, 0, 32'h18, 5'd1, 16'd50);
    run_check("wide-overlap", 0, 1, 32'h0F, 5'd18, 0, 0);
    // R4: uncacheable match is passed over
    clear_q(); set_ent(3, 1, 1, 32'h18, 5'd1, 16'd40);
    run_check("uncache-skip", 0, 1, 32'h18, 5'd1, 0, 0);
    // R5: younger than held violator stops the scan
    clear_q(); set_ent(4, 1, 0, 32'h30, 5'd4, 16'd80);
    run_check("younger-stop", 0, 1, 32'h30, 5'd1, 0, 0);
    set_ent(4, 1, 0, 32'h30, 5'd4, 16'd20);
    run_check("older-replace", 1, 1, 32'h30, 5'd1, 0, 0);
    // R3: wrap-around from slot 6 to entry 0
    clear_q(); tail = 3'd2; set_ent(0, 1, 0, 32'h200, 5'd8, 16'd7);
    run_check("wrap", 0, 6, 32'h204, 5'd1, 0, 0);
    // R8: record and clear on the same edge, then clear without record
    set_ent(0, 1, 0, 32'h200, 5'd8, 16'd3);
    run_check("rec-vs-clr", 0, 6, 32'h200, 5'd1, 1, 0);
    run_check("tail-vs-clr", 0, 6, 32'h900, 5'd1, 1, 0);
    // R10: request during busy is dropped
    clear_q(); tail = 3'd0; set_ent(6, 1, 0, 32'h500, 5'd1, 16'd9);
    run_check("poke", 0, 0, 32'h500, 5'd1, 0, 1);

    // R7: load disabled on dut_nl, store still scans
    @(negedge clk);
    req_nl = 1; req_ld_nl = 1; slot_nl = 3'd0;
    @(posedge clk); @(negedge clk); req_nl = 0;
    chk("R7 load done next cycle", {61'd0, done_nl, fault_nl, busy_nl}, 64'b100);
    chk("R7 load no record", {47'd0, vval_nl, vcnt_nl}, 64'd0);
    raddr = 32'h500; rsize = 5'd1;
    @(negedge clk);
    req_nl = 1; req_ld_nl = 0;
    @(posedge clk); @(negedge clk); req_nl = 0;
    for (int k = 0; k < 20 && !done_nl; k++) @(negedge clk);
    chk("R7 store scans", {62'd0, done_nl, fault_nl}, 64'b11);
    chk("R7 store seq", 64'(vseq_nl), 64'd9);

    // random phase
    for (int t = 0; t < 300; t++) begin
      for (int i = 0; i < DEPTH; i++)
        set_ent(i, ($urandom % 4) != 0, ($urandom % 8) == 0, AW'($urandom % 256),
                SW'(1 + $urandom % 20), QW'($urandom));
      tail = IW'($urandom);
      if ($urandom % 6 == 0) pulse_clr();
      run_check("random R1 R2 R3 R4 R5 R6", ($urandom % 2) == 1, int'($urandom % DEPTH),
                AW'($urandom % 256), SW'(1 + $urandom % 20), ($urandom % 5) == 0,
                ($urandom % 7) == 0);
    end

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog R3 actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule